// File: doc/BRIEF.md
# PC Speaker Tone Generator

This block produces the square-wave tone that drives the speaker of a PC-compatible system. It holds one programmable counter channel that runs as a square-wave rate generator, and a small system control port. The counter advances on a clock-enable pulse (`tick`) that marks each edge of the roughly 1.19 MHz timer input clock. Everything else runs on the system clock.

Software loads a 16-bit divisor into the counter data address as two byte writes, low byte first. The counter then produces a wave whose period is that many ticks. Two bits of the system control port shape the result. Bit 0 gates the counter's count input, and a 0-to-1 change of that bit restarts the wave. Bit 1 masks the finished wave before it reaches the speaker pin. A control word written to the mode address with the channel-select field equal to 2 resets the byte sequencing and halts the channel until a new count arrives.

Both control bits are clear after reset, so the speaker is silent. This block returns no data for reads of the system control port or the mode address.

Top module: `spkr_tone_gen`

## Requirements
- R1: After reset, `spkr_out` is 0, both control bits are 0, the stored count is 0 and a read of the counter data address (0x42) returns 0.
- R2: Writes to 0x42 alternate between the low byte and the high byte, starting with the low byte. The 16-bit count takes effect only when the high byte is written. A read of 0x42 returns the stored count's low byte when the next write would be a low byte, and its high byte otherwise.
- R3: For a count N from 2 to 65535, the first tick after the count completes sets the output high. After that the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, and this repeats with period N.
- R4: A count of 0 acts as 65536, giving 32768 ticks high and then 32768 ticks low. A count of 1 keeps the output high.
- R5: While bit 0 of the control port at 0x61 is 0, the counter does not advance and its output holds its value.
- R6: When a write changes bit 0 of 0x61 from 0 to 1, the next tick reloads the counter from the stored count and sets the output high, which starts a fresh period.
- R7: `spkr_out` is the counter output ANDed with bit 1 of 0x61. The counter keeps running while bit 1 is 0, so clearing the mask does not shift the wave's phase.
- R8: A write to 0x43 with bits [7:6] = 2'b10 resets the byte sequencing to the low byte and forces the counter output high. It also stops counting until a full new count is written. A write to 0x43 with any other value in bits [7:6] has no effect.
- R9: Reads of 0x61, 0x43 and any address other than 0x42 return 0. Writes to addresses other than 0x42, 0x43 and 0x61 change nothing.
- R10: A count completed while the wave is running takes effect on the next tick. That tick sets the output high and starts a new period of the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer input clock enable, one pulse per count |
| io_addr | input | 16 | I/O register address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| spkr_out | output | 1 | Speaker output level |

## Verification
A bad half-period length or a bad reload shows at `spkr_out` as a misplaced edge within one wave period. For small counts this is within a few dozen ticks. For a count of 0 the first wrong edge can appear only after 32768 ticks. A bad byte-sequencing state shows at once on a read of 0x42, which returns the other byte of the stored count. A gate or mask fault appears either as an edge while the gate is closed or as a wave phase that does not continue where it left off once the mask is set again. The sweep covers every count from 1 to 40 over two full periods, as well as the 65536 case.

// File: rtl/spkr_pkg.sv
package spkr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef logic [CNT_W-1:0] count_t;

  // ticks spent high in one period: ceil(N/2), count 0 meaning 2**CNT_W
  function automatic count_t high_len(input count_t n);
    if (n == '0) return count_t'(1) << (CNT_W - 1);
    return (n >> 1) + count_t'(n[0]);
  endfunction

  // ticks spent low in one period: floor(N/2), count 0 meaning 2**CNT_W
  function automatic count_t low_len(input count_t n);
    if (n == '0) return count_t'(1) << (CNT_W - 1);
    return n >> 1;
  endfunction
endpackage

// File: rtl/spkr_sysctl.sv
module spkr_sysctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wbits,
  output logic       gate,
  output logic       mask,
  output logic       gate_rise
);
  // a write that opens a closed gate is the rising-edge event
  assign gate_rise = wr_en & wbits[0] & ~gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate <= 1'b0;
      mask <= 1'b0;
    end else if (wr_en) begin
      gate <= wbits[0];
      mask <= wbits[1];
    end
  end
endmodule

// File: rtl/spkr_cnt_load.sv
module spkr_cnt_load
  import spkr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic              cfg_req,
  input  logic [BYTE_W-1:0] wdata,
  output count_t            count,
  output logic              ptr_hi,
  output logic              lo_wr,
  output logic              load_req,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] lo_stage;

  assign lo_wr    = cnt_wr & ~ptr_hi;
  assign load_req = cnt_wr &  ptr_hi;
  assign rd_byte  = ptr_hi ? count[CNT_W-1:BYTE_W] : count[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi   <= 1'b0;
      lo_stage <= '0;
      count    <= '0;
    end else if (cfg_req) begin
      ptr_hi <= 1'b0;
    end else if (lo_wr) begin
      lo_stage <= wdata;
      ptr_hi   <= 1'b1;
    end else if (load_req) begin
      count  <= {wdata, lo_stage};
      ptr_hi <= 1'b0;
    end
  end
endmodule

// File: rtl/spkr_sq_wave.sv
module spkr_sq_wave
  import spkr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   gate,
  input  logic   cfg_req,
  input  logic   load_req,
  input  logic   gate_rise,
  input  count_t count,
  output logic   sq_out,
  output logic   reload_fire
);
  logic   armed;    // a full count exists since the last control word
  logic   pend;     // reload waiting for the next tick
  count_t phase;    // ticks left in the current half period
  logic   run;

  assign run         = tick & gate & armed & ~cfg_req & ~load_req & ~gate_rise;
  assign reload_fire = run & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      pend   <= 1'b0;
      phase  <= '0;
      sq_out <= 1'b1;
    end else if (cfg_req) begin
      armed  <= 1'b0;
      pend   <= 1'b0;
      sq_out <= 1'b1;
    end else if (load_req) begin
      armed <= 1'b1;
      pend  <= 1'b1;
    end else if (gate_rise) begin
      pend <= 1'b1;
    end else if (run) begin
      if (pend) begin
        pend   <= 1'b0;
        sq_out <= 1'b1;
        phase  <= high_len(count);
      end else if (phase == count_t'(1)) begin
        if (sq_out && low_len(count) != '0) begin
          sq_out <= 1'b0;
          phase  <= low_len(count);
        end else begin
          sq_out <= 1'b1;
          phase  <= high_len(count);
        end
      end else begin
        phase <= phase - count_t'(1);
      end
    end
  end
endmodule

// File: rtl/spkr_tone_gen.sv
module spkr_tone_gen
  import spkr_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  CTL_ADDR  = 'h61,
  parameter logic [ADDR_W-1:0]  CNT_ADDR  = 'h42,
  parameter logic [ADDR_W-1:0]  MODE_ADDR = 'h43,
  parameter logic [1:0]         SEL_CODE  = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              spkr_out
);
  logic ctl_wr, cnt_wr, cfg_req;
  logic gate, mask, gate_rise;
  logic ptr_hi, lo_wr, load_req, reload_fire, sq_out;
  count_t count;
  logic [BYTE_W-1:0] rd_byte;

  assign ctl_wr  = io_wr && (io_addr == CTL_ADDR);
  assign cnt_wr  = io_wr && (io_addr == CNT_ADDR);
  assign cfg_req = io_wr && (io_addr == MODE_ADDR) && (io_wdata[7:6] == SEL_CODE);

  spkr_sysctl u_ctl (
    .clk, .rst_n, .wr_en(ctl_wr), .wbits(io_wdata[1:0]),
    .gate, .mask, .gate_rise
  );

  spkr_cnt_load u_load (
    .clk, .rst_n, .cnt_wr, .cfg_req, .wdata(io_wdata),
    .count, .ptr_hi, .lo_wr, .load_req, .rd_byte
  );

  spkr_sq_wave u_wave (
    .clk, .rst_n, .tick, .gate, .cfg_req, .load_req, .gate_rise,
    .count, .sq_out, .reload_fire
  );

  assign io_rdata = (io_addr == CNT_ADDR) ? rd_byte : '0;
  assign spkr_out = sq_out & mask;
endmodule

// File: rtl/spkr_tone_chk.sv
module spkr_tone_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic gate,
  input logic cfg_req,
  input logic lo_wr,
  input logic load_req,
  input logic reload_fire,
  input logic sq_out,
  input logic ptr_hi
);
  a_r2_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> ptr_hi);
  a_r2_high_closes: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !ptr_hi);
  a_r3_tick_paces: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_req) |=> $stable(sq_out));
  a_r5_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !cfg_req) |=> $stable(sq_out));
  a_r6_reload_high: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> sq_out);
  a_r8_cfg_resets: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> (sq_out && !ptr_hi));
endmodule

bind spkr_tone_gen spkr_tone_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .cfg_req(cfg_req),
  .lo_wr(lo_wr), .load_req(load_req), .reload_fire(reload_fire),
  .sq_out(sq_out), .ptr_hi(ptr_hi)
);

// File: tb/sim_spkr_tone_gen.sv
`timescale 1ns/1ps
module sim_spkr_tone_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        spkr_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spkr_tone_gen u0 (.clk, .rst_n, .tick, .io_addr, .io_wr, .io_wdata, .io_rdata, .spkr_out);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = '0;
  endtask

  task automatic rd(input logic [15:0] a, output int v);
    io_addr = a; #1; v = io_rdata; io_addr = '0;
  endtask

  task automatic set_count(input int n);
    wr(16'h0042, 8'(n & 255));
    wr(16'h0042, 8'((n >> 8) & 255));
  endtask

  // expected wave level k ticks after a reload (k = 1 is the reload tick)
  function automatic bit wave_lvl(input int n, input int k);
    int per, hi;
    per = (n == 0) ? 65536 : n;
    hi = (per + 1) / 2;
    return ((k - 1) % per) < hi;
  endfunction

  task automatic run_wave(input int n, input int k0, input int k1, input string req);
    int bad_k = -1;
    int act = 0;
    int ex = 0;
    tick = 1'b1;
    for (int k = k0; k <= k1; k++) begin
      @(negedge clk);
      if (bad_k < 0 && spkr_out !== wave_lvl(n, k)) begin
        bad_k = k; act = spkr_out; ex = wave_lvl(n, k);
      end
    end
    tick = 1'b0;
    if (bad_k >= 0) $display("FAIL detail %s n=%0d first bad tick %0d", req, n, bad_k);
    chk(bad_k < 0, req, act, ex);
  endtask

  task automatic hold_level(input int cycles, input bit lvl, input string req);
    int bad_c = -1;
    tick = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (bad_c < 0 && spkr_out !== lvl) bad_c = c;
    end
    tick = 1'b0;
    chk(bad_c < 0, req, bad_c, -1);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spkr_out === 1'b0, "R1 speaker silent", spkr_out, 0);
    rd(16'h0042, v); chk(v == 0, "R1 count reads 0", v, 0);
    rd(16'h0061, v); chk(v == 0, "R9 port 0x61 read", v, 0);

    wr(16'h0061, 8'h03);
    rd(16'h0061, v); chk(v == 0, "R9 port 0x61 read after write", v, 0);
    rd(16'h0043, v); chk(v == 0, "R9 mode address read", v, 0);

    // R2 byte sequencing
    set_count(16'hA5C3);
    rd(16'h0042, v); chk(v == 'hC3, "R2 low byte", v, 'hC3);
    wr(16'h0042, 8'h11);
    rd(16'h0042, v); chk(v == 'hA5, "R2 high byte after low write", v, 'hA5);
    wr(16'h0042, 8'h22);
    rd(16'h0042, v); chk(v == 'h11, "R2 new low byte", v, 'h11);
    rd(16'h0043, v); chk(v == 0, "R9 mode address still 0", v, 0);

    // R3 / R4 sweep of small counts over two periods
    for (int n = 1; n <= 40; n++) begin
      set_count(n);
      run_wave(n, 1, 2 * n + 1, (n == 1) ? "R4 count of one" : "R3 square wave");
    end
    set_count(1000);
    run_wave(1000, 1, 2001, "R3 square wave 1000");

    // R4 count 0 is 65536
    set_count(0);
    run_wave(0, 1, 65537, "R4 count of zero");

    // R10 new count mid-run
    set_count(10);
    run_wave(10, 1, 5, "R10 before reprogram");
    tick = 1'b1;
    set_count(6);
    run_wave(6, 1, 13, "R10 new count restarts");

    // R5 / R6 gate freeze and restart
    set_count(20);
    run_wave(20, 1, 14, "R5 setup");
    wr(16'h0061, 8'h02);
    hold_level(30, 1'b0, "R5 gate low holds output");
    wr(16'h0061, 8'h03);
    run_wave(20, 1, 41, "R6 gate rise restarts");

    // R7 mask after the counter
    wr(16'h0061, 8'h01);
    set_count(12);
    hold_level(30, 1'b0, "R7 masked output");
    wr(16'h0061, 8'h03);
    @(negedge clk);
    chk(spkr_out === wave_lvl(12, 30), "R7 unmask keeps phase", spkr_out, wave_lvl(12, 30));
    run_wave(12, 31, 60, "R7 wave continues");

    // R8 control words
    set_count(16'h0123);
    rd(16'h0042, v); chk(v == 'h23, "R8 setup low byte", v, 'h23);
    wr(16'h0042, 8'h55);
    rd(16'h0042, v); chk(v == 'h01, "R8 pointer at high", v, 'h01);
    wr(16'h0043, 8'h36);
    rd(16'h0042, v); chk(v == 'h01, "R8 other channel ignored", v, 'h01);
    wr(16'h0043, 8'hD6);
    rd(16'h0042, v); chk(v == 'h01, "R8 select 3 ignored", v, 'h01);
    wr(16'h0043, 8'hB6);
    rd(16'h0042, v); chk(v == 'h23, "R8 pointer reset", v, 'h23);
    chk(spkr_out === 1'b1, "R8 output forced high", spkr_out, 1);
    hold_level(20, 1'b1, "R8 counting halted");
    set_count(4);
    run_wave(4, 1, 9, "R8 runs after new count");

    // R9 writes elsewhere ignored
    wr(16'h0040, 8'hFF);
    wr(16'h0041, 8'h77);
    rd(16'h0042, v); chk(v == 'h04, "R9 other writes ignored", v, 'h04);
    rd(16'h0040, v); chk(v == 0, "R9 other address read", v, 0);
    run_wave(4, 10, 17, "R9 wave undisturbed");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule